// File: doc/BRIEF.md
# Two-Level Global-History Branch Direction Predictor

This block tells an instruction fetch unit whether the branch at a given fetch address is expected to be taken. It keeps a table of 2-bit entries. Each entry stores a predicted direction together with a flag that records whether the last prediction made from that entry was wrong. The table is split into four sets. A two-bit shift register holding the outcomes of the two most recently resolved branches picks the set, and the word-address bits of the PC pick the entry within that set.

A lookup is purely combinational: the fetch PC goes in and the prediction comes out in the same cycle. When a branch resolves later in the pipeline, the resolve port delivers its PC and its actual outcome. On the next clock edge the selected entry moves to its next state and the outcome is shifted into the history register. The history is sampled before that shift, for the update and for any lookup in the same cycle. Setting the history-enable parameter to zero leaves a single set, which makes the block a plain PC-indexed table.

Top module: `dirpred_top`

## Requirements
- R1: After reset every entry is in the state predict-not-taken/right and the history register holds zero, so every lookup returns not-taken.
- R2: An entry's state is 2 bits. Bit 1 is the predicted direction (1 = taken) and bit 0 is the wrong flag (1 = last prediction missed). Reset therefore leaves every entry at 2'b00, and `lookup_taken` is bit 1 of the addressed entry.
- R3: When a resolved outcome disagrees with an entry whose wrong flag is clear, only the wrong flag is set. The predicted direction does not change.
- R4: When a resolved outcome disagrees with an entry whose wrong flag is already set, the predicted direction inverts and the wrong flag clears. The direction therefore flips only after two consecutive misses.
- R5: When a resolved outcome agrees with the predicted direction, the wrong flag clears and the direction is kept.
- R6: The index within a set is PC bits [IDX_BITS+1:2]. PC bits [1:0] and all bits above IDX_BITS+1 have no effect on which entry is used.
- R7: With history enabled, the set is chosen by the 2-bit history {older, newer}. Each resolve shifts its outcome in as the newer bit, taking effect on the next cycle. Both the update and a lookup in the same cycle use the history as it was before the shift.
- R8: The table and the history change only on a cycle with `resolve_valid` high. Lookups alone never change them.
- R9: A lookup that addresses the entry being updated in the same cycle returns the entry's value from before the update.
- R10: With HIST_EN = 0 there is a single set indexed by PC bits alone, and resolved outcomes never change which entry a lookup uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lookup_pc | input | PC_W | Fetch PC to predict |
| lookup_taken | output | 1 | Predicted direction, same cycle |
| resolve_valid | input | 1 | A branch resolved this cycle |
| resolve_pc | input | PC_W | PC of the resolved branch |
| resolve_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
`lookup_taken` is due in the same cycle as `lookup_pc`. The effect of a resolve, on both the entry and the history, becomes visible one clock edge later. The bench drives inputs on the falling edge and samples the prediction 1 ns afterwards, before the rising edge that applies any resolve driven in that same step. Every sample therefore sees the state left by earlier steps only, which is exactly what R9 demands. A requirement-level model that is advanced only after each comparison tracks both a history-enabled instance and a single-set instance.

// File: rtl/dirpred_pkg.sv
package dirpred_pkg;

    // bit 1: predicted direction, bit 0: last prediction was wrong
    typedef enum logic [1:0] {
        ST_NT_RIGHT = 2'b00,
        ST_NT_WRONG = 2'b01,
        ST_TK_RIGHT = 2'b10,
        ST_TK_WRONG = 2'b11
    } dp_state_e;

    localparam int unsigned HIST_W = 2;

endpackage

// File: rtl/dirpred_index.sv
module dirpred_index #(
    parameter int unsigned PC_W     = 32,
    parameter int unsigned IDX_BITS = 6,
    parameter bit          HIST_EN  = 1'b1,
    localparam int unsigned AW      = IDX_BITS + (HIST_EN ? dirpred_pkg::HIST_W : 0)
) (
    input  logic [PC_W-1:0]                pc,
    input  logic [dirpred_pkg::HIST_W-1:0] hist,
    output logic [AW-1:0]                  idx
);
    logic [IDX_BITS-1:0] word_bits;
    assign word_bits = pc[IDX_BITS+1:2];

    generate
        if (HIST_EN) begin : g_hist
            assign idx = {hist, word_bits};
        end else begin : g_flat
            assign idx = word_bits;
        end
    endgenerate
endmodule

// File: rtl/dirpred_next.sv
module dirpred_next
    import dirpred_pkg::*;
(
    input  logic [1:0] cur,
    input  logic       taken,
    output logic [1:0] nxt
);
    dp_state_e cur_e;
    dp_state_e nxt_e;

    always_comb begin
        cur_e = dp_state_e'(cur);
        nxt_e = cur_e;
        unique case (cur_e)
            ST_TK_RIGHT: nxt_e = taken ? ST_TK_RIGHT : ST_TK_WRONG;
            ST_TK_WRONG: nxt_e = taken ? ST_TK_RIGHT : ST_NT_RIGHT;
            ST_NT_RIGHT: nxt_e = taken ? ST_NT_WRONG : ST_NT_RIGHT;
            ST_NT_WRONG: nxt_e = taken ? ST_TK_RIGHT : ST_NT_RIGHT;
            default:     nxt_e = ST_NT_RIGHT;
        endcase
        nxt = nxt_e;
    end
endmodule

// File: rtl/dirpred_hist.sv
module dirpred_hist
    import dirpred_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              taken,
    output logic [HIST_W-1:0] hist_q
);
    typedef struct packed {
        logic [HIST_W-1:0] bits;
    } hist_s;

    hist_s st_d;
    hist_s st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.bits = {st_q.bits[HIST_W-2:0], taken};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hist_q = st_q.bits;
endmodule

// File: rtl/dirpred_table.sv
module dirpred_table #(
    parameter int unsigned AW       = 8,
    localparam int unsigned ENTRIES = 1 << AW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        rd_idx,
    output logic [1:0]           rd_state,
    input  logic [AW-1:0]        wr_idx,
    output logic [1:0]           wr_old,
    input  logic                 wr_en,
    input  logic [1:0]           wr_state,
    output logic [ENTRIES*2-1:0] snapshot
);
    typedef struct packed {
        logic [ENTRIES-1:0][1:0] ent;
    } tbl_s;

    tbl_s st_d;
    tbl_s st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ent[wr_idx] = wr_state;
        end
    end

    // reset value 2'b00 is predict-not-taken/right
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_state = st_q.ent[rd_idx];
    assign wr_old   = st_q.ent[wr_idx];
    assign snapshot = st_q.ent;
endmodule

// File: rtl/dirpred_top.sv
module dirpred_top #(
    parameter int unsigned PC_W     = 32,
    parameter int unsigned IDX_BITS = 6,
    parameter bit          HIST_EN  = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lookup_pc,
    output logic            lookup_taken,
    input  logic            resolve_valid,
    input  logic [PC_W-1:0] resolve_pc,
    input  logic            resolve_taken
);
    import dirpred_pkg::*;

    localparam int unsigned AW      = IDX_BITS + (HIST_EN ? HIST_W : 0);
    localparam int unsigned ENTRIES = 1 << AW;

    logic [HIST_W-1:0]    hist_q;
    logic [AW-1:0]        look_idx;
    logic [AW-1:0]        res_idx;
    logic [1:0]           look_state;
    logic [1:0]           res_old;
    logic [1:0]           res_new;
    logic [ENTRIES*2-1:0] tbl_snap;

    dirpred_index #(.PC_W(PC_W), .IDX_BITS(IDX_BITS), .HIST_EN(HIST_EN)) u_look_idx (
        .pc   (lookup_pc),
        .hist (hist_q),
        .idx  (look_idx)
    );

    dirpred_index #(.PC_W(PC_W), .IDX_BITS(IDX_BITS), .HIST_EN(HIST_EN)) u_res_idx (
        .pc   (resolve_pc),
        .hist (hist_q),
        .idx  (res_idx)
    );

    dirpred_next u_next (
        .cur   (res_old),
        .taken (resolve_taken),
        .nxt   (res_new)
    );

    dirpred_table #(.AW(AW)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (look_idx),
        .rd_state (look_state),
        .wr_idx   (res_idx),
        .wr_old   (res_old),
        .wr_en    (resolve_valid),
        .wr_state (res_new),
        .snapshot (tbl_snap)
    );

    dirpred_hist u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (resolve_valid),
        .taken    (resolve_taken),
        .hist_q   (hist_q)
    );

    assign lookup_taken = look_state[1];
endmodule

// File: rtl/dirpred_checker.sv
module dirpred_checker #(
    parameter int unsigned AW       = 8,
    localparam int unsigned ENTRIES = 1 << AW
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 resolve_valid,
    input logic                 resolve_taken,
    input logic [1:0]           hist_q,
    input logic [AW-1:0]        res_idx,
    input logic [1:0]           res_old,
    input logic [ENTRIES*2-1:0] tbl_snap
);
    logic [AW-1:0] prev_idx_q;
    logic [1:0]    ent_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_idx_q <= '0;
        end else begin
            prev_idx_q <= res_idx;
        end
    end

    assign ent_prev = tbl_snap[{prev_idx_q, 1'b0} +: 2];

    assert_quiet_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !resolve_valid |=> ($stable(tbl_snap) && $stable(hist_q)));

    assert_hist_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resolve_valid |=> (hist_q == {$past(hist_q[0]), $past(resolve_taken)}));

    assert_first_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (resolve_valid && !res_old[0] && (res_old[1] != resolve_taken))
        |=> (ent_prev == {$past(res_old[1]), 1'b1}));

    assert_second_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (resolve_valid && res_old[0] && (res_old[1] != resolve_taken))
        |=> (ent_prev == {!$past(res_old[1]), 1'b0}));

    assert_hit_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (resolve_valid && (res_old[1] == resolve_taken))
        |=> (ent_prev == {$past(resolve_taken), 1'b0}));
endmodule

bind dirpred_top dirpred_checker #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .resolve_valid (resolve_valid),
    .resolve_taken (resolve_taken),
    .hist_q        (hist_q),
    .res_idx       (res_idx),
    .res_old       (res_old),
    .tbl_snap      (tbl_snap)
);

// File: tb/dirpred_top_test.sv
module dirpred_top_test;
    localparam int unsigned IDXB = 6;
    localparam int unsigned NV   = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lookup_pc = '0;
    logic        resolve_valid = 1'b0;
    logic [31:0] resolve_pc = '0;
    logic        resolve_taken = 1'b0;
    logic        lookup_taken;
    logic        flat_taken;

    int checks = 0;
    int fails  = 0;

    logic [1:0] m_tbl  [256];
    logic [1:0] m_flat [64];
    logic [1:0] m_hist;

    always #2 clk = ~clk;

    dirpred_top #(.PC_W(32), .IDX_BITS(IDXB), .HIST_EN(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .lookup_pc(lookup_pc), .lookup_taken(lookup_taken),
        .resolve_valid(resolve_valid), .resolve_pc(resolve_pc), .resolve_taken(resolve_taken)
    );

    dirpred_top #(.PC_W(32), .IDX_BITS(IDXB), .HIST_EN(1'b0)) uut_flat (
        .clk(clk), .rst_n(rst_n), .lookup_pc(lookup_pc), .lookup_taken(flat_taken),
        .resolve_valid(resolve_valid), .resolve_pc(resolve_pc), .resolve_taken(resolve_taken)
    );

    // {resolve_valid, resolve_pc[11:0], resolve_taken, lookup_pc[11:0]}
    localparam logic [25:0] VEC [NV] = '{
        {1'b1, 12'h080, 1'b1, 12'h080}, {1'b1, 12'h080, 1'b1, 12'h080},
        {1'b1, 12'h080, 1'b1, 12'h080}, {1'b1, 12'h080, 1'b0, 12'h080},
        {1'b0, 12'h000, 1'b0, 12'h080}, {1'b1, 12'h0C4, 1'b0, 12'h0C4},
        {1'b1, 12'h0C4, 1'b0, 12'h080}, {1'b1, 12'h080, 1'b1, 12'h0C4},
        {1'b1, 12'h080, 1'b1, 12'h080}, {1'b1, 12'h0FC, 1'b1, 12'h0FC},
        {1'b1, 12'h0FC, 1'b1, 12'h0FC}, {1'b1, 12'h0FC, 1'b1, 12'h0FC},
        {1'b0, 12'h000, 1'b0, 12'h0FC}, {1'b1, 12'h010, 1'b0, 12'h010},
        {1'b1, 12'h010, 1'b1, 12'h0FC}, {1'b1, 12'h010, 1'b0, 12'h010},
        {1'b1, 12'h010, 1'b1, 12'h010}, {1'b1, 12'h010, 1'b1, 12'h010},
        {1'b0, 12'h000, 1'b0, 12'h010}, {1'b0, 12'h000, 1'b0, 12'h080}
    };

    // model built from R2..R5: bit1 direction, bit0 wrong flag
    function automatic logic [1:0] next_of(input logic [1:0] s, input logic t);
        if (s[1] == t)  return {t, 1'b0};
        else if (s[0])  return {~s[1], 1'b0};
        else            return {s[1], 1'b1};
    endfunction

    function automatic int hidx(input logic [31:0] pc);
        return int'({m_hist, pc[IDXB+1:2]});
    endfunction

    function automatic int fidx(input logic [31:0] pc);
        return int'(pc[IDXB+1:2]);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 256; i++) m_tbl[i] = 2'b00;
        for (int i = 0; i < 64; i++) m_flat[i] = 2'b00;
        m_hist = 2'b00;
    endtask

    task automatic check(input logic act, input logic exp, input string tag, input string which);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s (%s): lookup_taken=%0b expected=%0b at %0t", tag, which, act, exp, $time);
        end
    endtask

    task automatic step(input logic uv, input logic [31:0] upc, input logic tk,
                        input logic [31:0] lpc, input string tag);
        @(negedge clk);
        resolve_valid = uv;
        resolve_pc    = upc;
        resolve_taken = tk;
        lookup_pc     = lpc;
        #1;
        check(lookup_taken, m_tbl[hidx(lpc)][1], tag, "history");
        check(flat_taken, m_flat[fidx(lpc)][1], tag, "single-set");
        if (uv) begin
            m_tbl[hidx(upc)]  = next_of(m_tbl[hidx(upc)], tk);
            m_flat[fidx(upc)] = next_of(m_flat[fidx(upc)], tk);
            m_hist = {m_hist[0], tk};
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        resolve_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        model_reset();
        do_reset();

        // R1 reset state, all not-taken
        step(1'b0, 32'h0, 1'b0, 32'h0000_0000, "R1");
        step(1'b0, 32'h0, 1'b0, 32'h0000_00FC, "R1");
        step(1'b0, 32'h0, 1'b0, 32'h1234_5678, "R1");

        // single-set instance: same entry 0x40, hand-checked comments for flat view
        step(1'b1, 32'h40, 1'b1, 32'h40, "R9");   // old value 0 returned
        step(1'b0, 32'h0, 1'b0, 32'h40, "R3");    // NT/wrong: still 0
        step(1'b1, 32'h40, 1'b1, 32'h40, "R4");   // still 0 this cycle
        step(1'b0, 32'h0, 1'b0, 32'h40, "R4");    // flipped: 1
        step(1'b1, 32'h40, 1'b0, 32'h40, "R3");   // TK/wrong
        step(1'b1, 32'h40, 1'b1, 32'h40, "R5");   // back to TK/right
        step(1'b1, 32'h40, 1'b0, 32'h40, "R5");   // TK/wrong, direction kept
        step(1'b0, 32'h0, 1'b0, 32'h40, "R5");    // 1
        step(1'b0, 32'h0, 1'b0, 32'h43, "R6");    // low bits ignored
        step(1'b0, 32'h0, 1'b0, 32'hF040, "R6");  // high bits alias
        step(1'b1, 32'h8040, 1'b1, 32'h40, "R6"); // alias update
        step(1'b0, 32'h0, 1'b0, 32'h40, "R8");
        step(1'b0, 32'h0, 1'b0, 32'h40, "R8");
        step(1'b0, 32'h0, 1'b0, 32'h44, "R10");

        // R7 history set selection, driven from the vector table
        for (int v = 0; v < NV; v++) begin
            step(VEC[v][25], {20'h0, VEC[v][24:13]}, VEC[v][12],
                 {20'h0, VEC[v][11:0]}, "R7");
        end

        // R2 reset mid-run restores 2'b00 everywhere
        do_reset();
        step(1'b0, 32'h0, 1'b0, 32'h80, "R2");
        step(1'b0, 32'h0, 1'b0, 32'hFC, "R2");
        step(1'b0, 32'h0, 1'b0, 32'h40, "R1");

        // R10 single set: history moves, flat entry still addressed by PC only
        step(1'b1, 32'h20, 1'b1, 32'h20, "R10");
        step(1'b1, 32'h20, 1'b1, 32'h20, "R10");
        step(1'b1, 32'h24, 1'b0, 32'h20, "R10");
        step(1'b0, 32'h0, 1'b0, 32'h20, "R10");

        @(negedge clk);
        resolve_valid = 1'b0;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule